// File: doc/BRIEF.md
# Keypad Hex Entry Shifting Display

This block reads hexadecimal digits from a 4x4 matrix keypad and keeps the most recent eight of them in a digit register. That register is shown on eight multiplexed common-anode seven-segment digits. The block drives the keypad columns low one at a time and watches the four row lines. When a row reads low, the column drive stops moving. The key must then stay low for a debounce window before it is taken. An accepted key moves every stored digit one place toward the left and puts the new digit in the rightmost place. Once all eight places hold entered digits, the leftmost digit is lost on the next press.

After a key is taken, the scanner waits until every key has read released for a full debounce window. Only then does it look for a new key, so one press gives exactly one shift. All timing comes from clock-enable counters on the one system clock. These counters set the column step, the debounce window and the display refresh step. The asynchronous active-low reset is released through a two-stage synchronizer. The row inputs pass through their own two-stage synchronizer.

Top module: `kpd_hex_entry`

## Requirements
- R1: After reset the digit register reads 0000_0000, the column drive is 1110 and the digit enables are 1111_1110.
- R2: Each accepted key moves every stored digit one place left and writes the key's value into the rightmost digit. For example, 1 and then 2 from reset gives 0000_0012.
- R3: With all eight places holding entered digits, a further key drops the leftmost digit. For example, 486C_8763 and then key 1 gives 86C8_7631.
- R4: While no key is held, the active-low column drive steps every SCAN_DIV clocks through 1110, 1101, 1011, 0111 and then back to 1110. Exactly one column is low at any time.
- R5: Key values: column 0111 gives 0,1,2,3 for rows 0111,1011,1101,1110 in that order. Column 1011 gives 4 to 7, column 1101 gives 8 to B and column 1110 gives C to F.
- R6: The segment output is active low as {dp,g,f,e,d,c,b,a}, with the decimal point always off. Values 0..F encode as C0,F9,A4,B0,99,92,82,F8,80,98,88,83,C6,A1,86,8E.
- R7: The active-low digit enables are one-hot. Enable bit i goes low together with digit i, where digit 0 is the rightmost (least significant nibble). The enables step from bit 0 to bit 7 and wrap.
- R8: The low enable moves to the next digit once every REFRESH_DIV clocks.
- R9: A key that reads low for fewer than DEB_CYC clocks causes no shift.
- R10: A key held for any length of time causes exactly one shift. No further key is taken until all rows read high for DEB_CYC consecutive clocks.
- R11: While a key is detected or held, the column drive stays on that key's column.
- R12: If several keys in the detected column are down together, the lowest-valued one is taken. Keys pressed while another key is held are ignored until every key is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_n | input | 4 | Keypad row lines, low when a key in the driven column is down |
| col_n | output | 4 | Keypad column drive, one column low at a time |
| an_n | output | NDIG | Active-low digit enables, one-hot |
| seg_n | output | 8 | Active-low segments {dp,g,f,e,d,c,b,a} |

## Verification
The assertions take for granted that a row line reads low only while the column of a pressed key is driven. They also assume DEB_CYC is long enough to cover a full column sweep plus the synchronizer delay, so that a release window always sees every column. The keypad model in the bench derives the rows from the column drive at every instant. Every press and release it makes is held far longer or far shorter than the debounce window, never near its edge. Overlapping presses are arranged so that the outcome does not depend on where the scan happens to be.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

  typedef enum logic [1:0] {
    ST_SCAN  = 2'd0,
    ST_PRESS = 2'd1,
    ST_HELD  = 2'd2,
    ST_REL   = 2'd3
  } scan_st_e;

  // Position of the first low line counted from the MSB: 0111 -> 0 ... 1110 -> 3.
  function automatic logic [1:0] low_pos(input logic [3:0] v);
    logic [1:0] p;
    if (!v[3])      p = 2'd0;
    else if (!v[2]) p = 2'd1;
    else if (!v[1]) p = 2'd2;
    else            p = 2'd3;
    return p;
  endfunction

  // Active-low segment pattern {dp,g,f,e,d,c,b,a}, decimal point off.
  function automatic logic [7:0] hex_to_seg(input logic [3:0] v);
    logic [7:0] s;
    case (v)
      4'h0: s = 8'hC0;
      4'h1: s = 8'hF9;
      4'h2: s = 8'hA4;
      4'h3: s = 8'hB0;
      4'h4: s = 8'h99;
      4'h5: s = 8'h92;
      4'h6: s = 8'h82;
      4'h7: s = 8'hF8;
      4'h8: s = 8'h80;
      4'h9: s = 8'h98;
      4'hA: s = 8'h88;
      4'hB: s = 8'h83;
      4'hC: s = 8'hC6;
      4'hD: s = 8'hA1;
      4'hE: s = 8'h86;
      default: s = 8'h8E;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/kpd_scan.sv
module kpd_scan
  import kpd_pkg::*;
#(
  parameter int SCAN_DIV = 50000,
  parameter int DEB_CYC  = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] row_s,
  output logic [3:0] col_n,
  output logic       key_hit,
  output logic [3:0] key_code
);
  localparam int DIV_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam int DEB_W = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCAN_DIV - 1);
  localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(DEB_CYC - 1);

  scan_st_e         st_q, st_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DEB_W-1:0] deb_q, deb_d;
  logic [3:0]       col_q, col_d;
  logic [1:0]       row_q, row_d;
  logic             hit_q, hit_d;
  logic [3:0]       code_q, code_d;
  logic             tick;
  logic             any_low;
  logic [3:0]       col_next;

  assign tick     = (div_q == DIV_LAST);
  assign any_low  = (row_s != 4'hF);
  assign col_next = {col_q[2:0], col_q[3]};

  always_comb begin
    st_d   = st_q;
    div_d  = tick ? '0 : div_q + 1'b1;
    deb_d  = deb_q;
    col_d  = col_q;
    row_d  = row_q;
    hit_d  = 1'b0;
    code_d = code_q;
    case (st_q)
      ST_SCAN: begin
        if (tick) begin
          if (any_low) begin
            row_d = low_pos(row_s);
            deb_d = '0;
            st_d  = ST_PRESS;
          end else begin
            col_d = col_next;
          end
        end
      end
      ST_PRESS: begin
        if (!row_s[2'd3 - row_q]) begin
          if (deb_q == DEB_LAST) begin
            hit_d  = 1'b1;
            code_d = {low_pos(col_q), row_q};
            st_d   = ST_HELD;
          end else begin
            deb_d = deb_q + 1'b1;
          end
        end else begin
          st_d = ST_SCAN;
        end
      end
      ST_HELD: begin
        if (!any_low) begin
          deb_d = '0;
          st_d  = ST_REL;
        end
      end
      default: begin
        if (tick) col_d = col_next;
        if (any_low) begin
          deb_d = '0;
        end else if (deb_q == DEB_LAST) begin
          st_d = ST_SCAN;
        end else begin
          deb_d = deb_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SCAN;
      div_q  <= '0;
      deb_q  <= '0;
      col_q  <= 4'b1110;
      row_q  <= '0;
      hit_q  <= 1'b0;
      code_q <= '0;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      deb_q  <= deb_d;
      col_q  <= col_d;
      row_q  <= row_d;
      hit_q  <= hit_d;
      code_q <= code_d;
    end
  end

  assign col_n    = col_q;
  assign key_hit  = hit_q;
  assign key_code = code_q;

  // R4
  col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(~col_q));

  // R11
  col_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HELD || st_q == ST_PRESS) |=> ((st_q != ST_HELD && st_q != ST_PRESS) || $stable(col_q)));

  // R10
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> (st_q != ST_PRESS && st_q != ST_SCAN));
endmodule

// File: rtl/kpd_digit_shift.sv
module kpd_digit_shift #(
  parameter int NDIG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic [3:0]      din,
  output logic [NDIG*4-1:0] digits
);
  localparam int DW = NDIG * 4;

  logic [DW-1:0] dig_q, dig_d;

  always_comb begin
    dig_d = dig_q;
    if (shift_en) dig_d = {dig_q[DW-5:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dig_q <= '0;
    else        dig_q <= dig_d;
  end

  assign digits = dig_q;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(dig_q));

  // R2
  new_digit_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (dig_q[3:0] == $past(din)));
endmodule

// File: rtl/kpd_disp_mux.sv
module kpd_disp_mux
  import kpd_pkg::*;
#(
  parameter int NDIG        = 8,
  parameter int REFRESH_DIV = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NDIG*4-1:0] digits,
  output logic [NDIG-1:0]   an_n,
  output logic [7:0]        seg_n
);
  localparam int SEL_W = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam int RF_W  = (REFRESH_DIV > 1) ? $clog2(REFRESH_DIV) : 1;
  localparam logic [RF_W-1:0]  RF_LAST  = RF_W'(REFRESH_DIV - 1);
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NDIG - 1);

  logic [RF_W-1:0]  rf_q, rf_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             step;
  logic [3:0]       cur_dig;

  assign step = (rf_q == RF_LAST);

  always_comb begin
    rf_d  = step ? '0 : rf_q + 1'b1;
    sel_d = sel_q;
    if (step) sel_d = (sel_q == SEL_LAST) ? '0 : sel_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_q  <= '0;
      sel_q <= '0;
    end else begin
      rf_q  <= rf_d;
      sel_q <= sel_d;
    end
  end

  for (genvar i = 0; i < NDIG; i++) begin : g_en
    assign an_n[i] = (sel_q != SEL_W'(i));
  end

  assign cur_dig = digits[sel_q*4 +: 4];
  assign seg_n   = hex_to_seg(cur_dig);

  // R7
  enable_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(~an_n));

  // R6
  dp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_n[7]);

  // R8
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(an_n));
endmodule

// File: rtl/kpd_hex_entry.sv
module kpd_hex_entry #(
  parameter int NDIG        = 8,
  parameter int SCAN_DIV    = 50000,
  parameter int DEB_CYC     = 500000,
  parameter int REFRESH_DIV = 50000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      row_n,
  output logic [3:0]      col_n,
  output logic [NDIG-1:0] an_n,
  output logic [7:0]      seg_n
);
  logic              rst_s_n;
  logic [3:0]        row_s;
  logic              hit;
  logic [3:0]        code;
  logic [NDIG*4-1:0] digits;

  kpd_sync #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_s_n)
  );

  kpd_sync #(.W(4), .RST_VAL(4'hF)) u_row_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     (row_n),
    .q     (row_s)
  );

  kpd_scan #(.SCAN_DIV(SCAN_DIV), .DEB_CYC(DEB_CYC)) u_scan (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .row_s    (row_s),
    .col_n    (col_n),
    .key_hit  (hit),
    .key_code (code)
  );

  kpd_digit_shift #(.NDIG(NDIG)) u_shift (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .shift_en (hit),
    .din      (code),
    .digits   (digits)
  );

  kpd_disp_mux #(.NDIG(NDIG), .REFRESH_DIV(REFRESH_DIV)) u_disp (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .digits (digits),
    .an_n   (an_n),
    .seg_n  (seg_n)
  );
endmodule

// File: tb/tb_kpd_hex_entry.sv
module tb_kpd_hex_entry;
  localparam int CLK_PERIOD = 10;
  localparam int NDIG = 8;
  localparam int SDIV = 4;
  localparam int DEB  = 24;
  localparam int RDIV = 2;
  localparam logic [7:0] SEGS [16] = '{8'hC0, 8'hF9, 8'hA4, 8'hB0, 8'h99, 8'h92, 8'h82, 8'hF8,
                                       8'h80, 8'h98, 8'h88, 8'h83, 8'hC6, 8'hA1, 8'h86, 8'h8E};

  logic            clk;
  logic            rst_n;
  logic [3:0]      row_n;
  logic [3:0]      col_n;
  logic [NDIG-1:0] an_n;
  logic [7:0]      seg_n;
  logic [15:0]     keys;
  logic [31:0]     exp_val;
  int checks;
  int errors;

  kpd_hex_entry #(.NDIG(NDIG), .SCAN_DIV(SDIV), .DEB_CYC(DEB), .REFRESH_DIV(RDIV)) dut (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n), .an_n(an_n), .seg_n(seg_n));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Keypad model: key k sits in column (3 - k/4) and row (3 - k%4), both counted as bit index.
  always_comb begin
    row_n = 4'hF;
    for (int k = 0; k < 16; k++) begin
      if (keys[k] && !col_n[3 - k/4]) row_n[3 - k%4] = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_disp(output logic [31:0] val, output bit good);
    bit seen [NDIG];
    val = '0;
    good = 1'b1;
    for (int i = 0; i < NDIG; i++) seen[i] = 1'b0;
    for (int s = 0; s < 2*NDIG*RDIV + 4; s++) begin
      @(negedge clk);
      if ($countones(~an_n) != 1) good = 1'b0;
      for (int i = 0; i < NDIG; i++) begin
        if (!an_n[i]) begin
          bit hit;
          hit = 1'b0;
          for (int v = 0; v < 16; v++) begin
            if (seg_n == SEGS[v]) begin
              val[i*4 +: 4] = 4'(v);
              hit = 1'b1;
            end
          end
          if (!hit) good = 1'b0;
          seen[i] = 1'b1;
        end
      end
    end
    for (int i = 0; i < NDIG; i++) if (!seen[i]) good = 1'b0;
  endtask

  task automatic check_disp(input string req);
    logic [31:0] v;
    bit g;
    read_disp(v, g);
    check(g && v == exp_val, req, v, exp_val);
  endtask

  task automatic press(input int k, input int hold);
    keys[k] = 1'b1;
    repeat (hold) @(negedge clk);
    keys[k] = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    keys = '0;
    exp_val = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: internal reset still held by the synchronizer; idle values visible
    check(col_n == 4'b1110 && an_n == 8'hFE, "R1", {20'h0, col_n, an_n}, {20'h0, 4'b1110, 8'hFE});
    repeat (3) @(negedge clk);
    check_disp("R1");

    // R4: column rotation order while idle
    begin
      logic [3:0] prev;
      bit ok;
      int steps;
      int gap;
      int gap_ok;
      ok = 1'b1; steps = 0; gap = 0; gap_ok = 1;
      prev = col_n;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        gap++;
        if (col_n != prev) begin
          if (col_n != {prev[2:0], prev[3]}) ok = 1'b0;
          if (steps > 0 && gap != SDIV) gap_ok = 0;
          steps++; gap = 0;
        end
        prev = col_n;
      end
      check(ok && steps >= 8 && gap_ok == 1, "R4", 32'(steps), 32'd9);
    end

    // R8: enable step interval
    begin
      logic [NDIG-1:0] p;
      int gap;
      int first;
      int bad;
      p = an_n; gap = 0; first = 1; bad = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        gap++;
        if (an_n != p) begin
          if (!first && gap != RDIV) bad = 1;
          if (an_n != {p[NDIG-2:0], p[NDIG-1]}) bad = 1;
          first = 0; gap = 0;
        end
        p = an_n;
      end
      check(bad == 0, "R8 R7", 32'(bad), 32'd0);
    end

    // R2 R3 R5 R6 R7: sweep all sixteen keys
    for (int k = 0; k < 16; k++) begin
      press(k, 80);
      exp_val = {exp_val[27:0], 4'(k)};
      check_disp(k < 8 ? "R2 R5 R6" : "R3 R5 R6");
    end

    // R3: worked example
    begin
      int seq [8] = '{4, 8, 6, 12, 8, 7, 6, 3};
      foreach (seq[i]) begin
        press(seq[i], 80);
        exp_val = {exp_val[27:0], 4'(seq[i])};
      end
      check_disp("R2");
      press(1, 80);
      exp_val = {exp_val[27:0], 4'h1};
      check(exp_val == 32'h86C87631, "R3 model", exp_val, 32'h86C87631);
      check_disp("R3");
    end

    // R9: short bounce is ignored
    press(5, 10);
    check_disp("R9");

    // R10 R11: long hold, column frozen, single shift
    begin
      bit froze;
      froze = 1'b1;
      keys[9] = 1'b1;
      repeat (80) @(negedge clk);
      for (int c = 0; c < 200; c++) begin
        @(negedge clk);
        if (col_n != 4'b1101) froze = 1'b0;
      end
      check(froze, "R11", {28'h0, col_n}, {28'h0, 4'b1101});
      repeat (300) @(negedge clk);
      keys[9] = 1'b0;
      repeat (80) @(negedge clk);
      exp_val = {exp_val[27:0], 4'h9};
      check_disp("R10");
    end

    // R12: two keys in the same column at once, lowest wins
    keys[4] = 1'b1; keys[6] = 1'b1;
    repeat (80) @(negedge clk);
    keys = '0;
    repeat (80) @(negedge clk);
    exp_val = {exp_val[27:0], 4'h4};
    check_disp("R12");

    // R12: a second key pressed while the first is held is ignored
    keys[10] = 1'b1;
    repeat (80) @(negedge clk);
    keys[5] = 1'b1;
    repeat (60) @(negedge clk);
    keys[10] = 1'b0;
    repeat (100) @(negedge clk);
    keys[5] = 1'b0;
    repeat (80) @(negedge clk);
    exp_val = {exp_val[27:0], 4'hA};
    check_disp("R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule